// File: doc/BRIEF.md
# Flag-Synchronised Dual-Clock Link Memory

This block is the shared memory that sits between two neighbouring processing elements in a linear array. Each neighbour drives its own port, left or right, on its own clock, and may start a read or a write on every cycle of that clock. Both ports may work at once. Data written through either port can be read through either port.

Besides the storage, the block holds two one-bit synchronisation flags. Either port can set or clear either flag. Each port can also test a flag against an expected value; while the test fails, the port's wait output is high, so the attached element can hold its instruction until its neighbour hands over a block of memory. A flag change made by one side is carried into the other side's clock domain through a two-stage synchroniser.

Top module: `flagLinkMem`

## Requirements
- R1: During and right after reset both flags read as clear at both ports and both read-data outputs are zero.
- R2: A read at a port puts the word at that address on the port's read-data output after the next rising edge of the port's own clock.
- R3: A word written through one port can be read back through the other port.
- R4: The two ports can write different addresses in overlapping cycles, and each write is kept.
- R5: When both ports write the same address at different times, the most recent write is the one later read through either port.
- R6: A read and a write to the same address on the same port in the same cycle returns the word stored before that write.
- R7: A set or clear made by a port is seen by that same port's flag test from the next cycle of its clock.
- R8: A set or clear made by one port is seen by the other port's flag test no later than three cycles of the other port's clock after the request.
- R9: The two flags (select 0 and select 1) change independently; an operation on one leaves the other unchanged. Flag operation code: 0 none, 1 set, 2 clear.
- R10: A port's wait output is high exactly when its test enable is high and the selected flag differs from the expected value; with test enable low it stays low.
- R11: When the right port is writing an address at the moment the left port writes the same address, the right port's word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkL | input | 1 | Left port clock |
| clkR | input | 1 | Right port clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| memEnL | input | 1 | Left access enable |
| memWeL | input | 1 | Left write enable (with memEnL) |
| memAddrL | input | 6 | Left word address |
| memWDataL | input | 32 | Left write data |
| memRDataL | output | 32 | Left read data, registered |
| flagOpL | input | 2 | Left flag operation: 0 none, 1 set, 2 clear |
| flagSelL | input | 1 | Left flag operation target |
| testEnL | input | 1 | Left flag test enable |
| testSelL | input | 1 | Left flag under test |
| testValL | input | 1 | Left expected flag value |
| waitL | output | 1 | Left hold request while the test fails |
| memEnR | input | 1 | Right access enable |
| memWeR | input | 1 | Right write enable (with memEnR) |
| memAddrR | input | 6 | Right word address |
| memWDataR | input | 32 | Right write data |
| memRDataR | output | 32 | Right read data, registered |
| flagOpR | input | 2 | Right flag operation: 0 none, 1 set, 2 clear |
| flagSelR | input | 1 | Right flag operation target |
| testEnR | input | 1 | Right flag test enable |
| testSelR | input | 1 | Right flag under test |
| testValR | input | 1 | Right expected flag value |
| waitR | output | 1 | Right hold request while the test fails |

## Verification
Read data is due one rising edge of the requesting port's clock after the request, so the bench queues the expected word when it sees that edge and compares at the following falling edge. A local flag change is due one edge after the request and a wait output follows the test inputs within the same cycle, so wait is sampled one nanosecond after the test inputs are driven. A flag change from the far side needs up to three edges of the observing clock; the bench waits six of them before testing, which keeps the check clear of the synchroniser's uncertainty.

// File: rtl/flm_pkg.sv
package flm_pkg;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 6;
  parameter int NUM_FLAGS = 2;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int FSEL_W   = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

  typedef enum logic [1:0] {
    FLAG_NOP = 2'd0,
    FLAG_SET = 2'd1,
    FLAG_CLR = 2'd2
  } flagOp_t;

  // Strobes handed from a port controller to the datapath
  typedef struct packed {
    logic              en;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } memStrobe_t;
endpackage

// File: rtl/flm_port_ctl.sv
module flm_port_ctl
  import flm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 memEn,
  input  logic                 memWe,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic [DATA_W-1:0]    memWData,
  input  logic [1:0]           flagOpIn,
  input  logic [FSEL_W-1:0]    flagSel,
  input  logic                 testEn,
  input  logic [FSEL_W-1:0]    testSel,
  input  logic                 testVal,
  input  logic [NUM_FLAGS-1:0] remSetTgl,
  input  logic [NUM_FLAGS-1:0] remClrTgl,
  output memStrobe_t           strobe,
  output logic [NUM_FLAGS-1:0] setTgl,
  output logic [NUM_FLAGS-1:0] clrTgl,
  output logic [NUM_FLAGS-1:0] flagView,
  output logic                 waitFlag
);
  flagOp_t op;
  assign op = flagOp_t'(flagOpIn);

  assign strobe = '{en: memEn, we: memWe, addr: memAddr, wdata: memWData};

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    logic [2:0] setSync;
    logic [2:0] clrSync;
    logic       setTglQ;
    logic       clrTglQ;
    logic       viewQ;
    logic       localSet;
    logic       localClr;
    logic       remSetEdge;
    logic       remClrEdge;

    assign localSet   = (op == FLAG_SET) && (flagSel == FSEL_W'(f));
    assign localClr   = (op == FLAG_CLR) && (flagSel == FSEL_W'(f));
    assign remSetEdge = setSync[1] ^ setSync[2];
    assign remClrEdge = clrSync[1] ^ clrSync[2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        setSync <= '0;
        clrSync <= '0;
        setTglQ <= 1'b0;
        clrTglQ <= 1'b0;
        viewQ   <= 1'b0;
      end else begin
        setSync <= {setSync[1:0], remSetTgl[f]};
        clrSync <= {clrSync[1:0], remClrTgl[f]};
        if (localSet) setTglQ <= ~setTglQ;
        if (localClr) clrTglQ <= ~clrTglQ;
        // own request is newest in this domain; then remote clear, then remote set
        if (localSet)        viewQ <= 1'b1;
        else if (localClr)   viewQ <= 1'b0;
        else if (remClrEdge) viewQ <= 1'b0;
        else if (remSetEdge) viewQ <= 1'b1;
      end
    end

    assign setTgl[f]   = setTglQ;
    assign clrTgl[f]   = clrTglQ;
    assign flagView[f] = viewQ;
  end

  assign waitFlag = testEn && (flagView[testSel] != testVal);
endmodule

// File: rtl/flm_datapath.sv
module flm_datapath
  import flm_pkg::*;
(
  input  logic              clkL,
  input  logic              clkR,
  input  logic              rstN,
  input  memStrobe_t        stbL,
  input  memStrobe_t        stbR,
  output logic [DATA_W-1:0] rdL,
  output logic [DATA_W-1:0] rdR
);
  // one array per writing port; ownership bits say which copy is newest
  logic [DATA_W-1:0] memL [DEPTH];
  logic [DATA_W-1:0] memR [DEPTH];
  logic [DEPTH-1:0]  ownL;
  logic [DEPTH-1:0]  ownR;
  logic              wrL;
  logic              wrR;
  logic              rightClaims;

  assign wrL         = stbL.en && stbL.we;
  assign wrR         = stbR.en && stbR.we;
  assign rightClaims = wrR && (stbR.addr == stbL.addr);

  always_ff @(posedge clkL) begin
    if (wrL) memL[stbL.addr] <= stbL.wdata;
  end

  always_ff @(posedge clkR) begin
    if (wrR) memR[stbR.addr] <= stbR.wdata;
  end

  always_ff @(posedge clkL or negedge rstN) begin
    if (!rstN) begin
      ownL <= '0;
      rdL  <= '0;
    end else begin
      if (wrL && !rightClaims) ownL[stbL.addr] <= ownR[stbL.addr];
      if (stbL.en)
        rdL <= (ownL[stbL.addr] ^ ownR[stbL.addr]) ? memR[stbL.addr] : memL[stbL.addr];
    end
  end

  always_ff @(posedge clkR or negedge rstN) begin
    if (!rstN) begin
      ownR <= '0;
      rdR  <= '0;
    end else begin
      if (wrR) ownR[stbR.addr] <= ~ownL[stbR.addr];
      if (stbR.en)
        rdR <= (ownL[stbR.addr] ^ ownR[stbR.addr]) ? memR[stbR.addr] : memL[stbR.addr];
    end
  end
endmodule

// File: rtl/flagLinkMem.sv
module flagLinkMem
  import flm_pkg::*;
(
  input  logic              clkL,
  input  logic              clkR,
  input  logic              rstN,
  input  logic              memEnL,
  input  logic              memWeL,
  input  logic [ADDR_W-1:0] memAddrL,
  input  logic [DATA_W-1:0] memWDataL,
  output logic [DATA_W-1:0] memRDataL,
  input  logic [1:0]        flagOpL,
  input  logic [FSEL_W-1:0] flagSelL,
  input  logic              testEnL,
  input  logic [FSEL_W-1:0] testSelL,
  input  logic              testValL,
  output logic              waitL,
  input  logic              memEnR,
  input  logic              memWeR,
  input  logic [ADDR_W-1:0] memAddrR,
  input  logic [DATA_W-1:0] memWDataR,
  output logic [DATA_W-1:0] memRDataR,
  input  logic [1:0]        flagOpR,
  input  logic [FSEL_W-1:0] flagSelR,
  input  logic              testEnR,
  input  logic [FSEL_W-1:0] testSelR,
  input  logic              testValR,
  output logic              waitR
);
  memStrobe_t          stbL;
  memStrobe_t          stbR;
  logic [NUM_FLAGS-1:0] setTglL, clrTglL, setTglR, clrTglR;
  logic [NUM_FLAGS-1:0] viewL, viewR;

  flm_port_ctl ctlL_i (
    .clk(clkL), .rstN(rstN), .memEn(memEnL), .memWe(memWeL), .memAddr(memAddrL),
    .memWData(memWDataL), .flagOpIn(flagOpL), .flagSel(flagSelL), .testEn(testEnL),
    .testSel(testSelL), .testVal(testValL), .remSetTgl(setTglR), .remClrTgl(clrTglR),
    .strobe(stbL), .setTgl(setTglL), .clrTgl(clrTglL), .flagView(viewL), .waitFlag(waitL)
  );

  flm_port_ctl ctlR_i (
    .clk(clkR), .rstN(rstN), .memEn(memEnR), .memWe(memWeR), .memAddr(memAddrR),
    .memWData(memWDataR), .flagOpIn(flagOpR), .flagSel(flagSelR), .testEn(testEnR),
    .testSel(testSelR), .testVal(testValR), .remSetTgl(setTglL), .remClrTgl(clrTglL),
    .strobe(stbR), .setTgl(setTglR), .clrTgl(clrTglR), .flagView(viewR), .waitFlag(waitR)
  );

  flm_datapath dp_i (
    .clkL(clkL), .clkR(clkR), .rstN(rstN), .stbL(stbL), .stbR(stbR),
    .rdL(memRDataL), .rdR(memRDataR)
  );
endmodule

// File: rtl/flm_checker.sv
module flm_checker
  import flm_pkg::*;
(
  input logic                 clkL,
  input logic                 clkR,
  input logic                 rstN,
  input logic [1:0]           flagOpL,
  input logic [1:0]           flagOpR,
  input logic [FSEL_W-1:0]    flagSelL,
  input logic [FSEL_W-1:0]    flagSelR,
  input logic                 testEnL,
  input logic                 testEnR,
  input logic [FSEL_W-1:0]    testSelL,
  input logic [FSEL_W-1:0]    testSelR,
  input logic                 testValL,
  input logic                 testValR,
  input logic                 waitL,
  input logic                 waitR,
  input logic [NUM_FLAGS-1:0] viewL,
  input logic [NUM_FLAGS-1:0] viewR
);
  AST_SET_SEEN_LOCAL: assert property (@(posedge clkL) disable iff (!rstN)
    (flagOpL == FLAG_SET && flagSelL == '0) |=> viewL[0]); // R7

  AST_CLR_SEEN_LOCAL: assert property (@(posedge clkR) disable iff (!rstN)
    (flagOpR == FLAG_CLR && flagSelR == '0) |=> !viewR[0]); // R7

  AST_NO_WAIT_IDLE: assert property (@(posedge clkL) disable iff (!rstN)
    !testEnL |-> !waitL); // R10

  AST_WAIT_ON_MISMATCH: assert property (@(posedge clkR) disable iff (!rstN)
    (testEnR && viewR[testSelR] != testValR) |-> waitR); // R10

  AST_NO_WAIT_ON_MATCH: assert property (@(posedge clkL) disable iff (!rstN)
    (testEnL && viewL[testSelL] == testValL) |-> !waitL); // R10

  always @(negedge clkL) begin
    if (!rstN) AST_RESET_CLEAR: assert (viewL == '0 && viewR == '0); // R1
  end
endmodule

bind flagLinkMem flm_checker chk_i (.*);

// File: tb/flagLinkMem_tb_top.sv
module flagLinkMem_tb_top;
  logic        clkL = 0, clkR = 0, rstN = 0;
  logic        memEnL = 0, memWeL = 0, memEnR = 0, memWeR = 0;
  logic [5:0]  memAddrL = 0, memAddrR = 0;
  logic [31:0] memWDataL = 0, memWDataR = 0, memRDataL, memRDataR;
  logic [1:0]  flagOpL = 0, flagOpR = 0;
  logic        flagSelL = 0, flagSelR = 0, testEnL = 0, testEnR = 0;
  logic        testSelL = 0, testSelR = 0, testValL = 0, testValR = 0;
  logic        waitL, waitR;
  int          nChecks = 0, nFail = 0;
  bit          done = 0;
  logic [31:0] expQL[$], expQR[$];
  string       reqQL[$], reqQR[$];

  always #5 clkL = ~clkL;
  always #7 clkR = ~clkR;

  flagLinkMem dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitors: compare queued expectations one edge after the request
  always @(negedge clkL) if (expQL.size() > 0) begin
    check(memRDataL === expQL[0], reqQL[0], memRDataL, expQL[0]);
    void'(expQL.pop_front()); void'(reqQL.pop_front());
  end
  always @(negedge clkR) if (expQR.size() > 0) begin
    check(memRDataR === expQR[0], reqQR[0], memRDataR, expQR[0]);
    void'(expQR.pop_front()); void'(reqQR.pop_front());
  end

  task automatic accL(input bit we, input logic [5:0] a, input logic [31:0] d,
                      input bit rd, input logic [31:0] exp, input string req);
    @(negedge clkL); memEnL = 1; memWeL = we; memAddrL = a; memWDataL = d;
    @(posedge clkL); if (rd) begin expQL.push_back(exp); reqQL.push_back(req); end
    @(negedge clkL); memEnL = 0; memWeL = 0;
  endtask

  task automatic accR(input bit we, input logic [5:0] a, input logic [31:0] d,
                      input bit rd, input logic [31:0] exp, input string req);
    @(negedge clkR); memEnR = 1; memWeR = we; memAddrR = a; memWDataR = d;
    @(posedge clkR); if (rd) begin expQR.push_back(exp); reqQR.push_back(req); end
    @(negedge clkR); memEnR = 0; memWeR = 0;
  endtask

  task automatic flagL(input logic [1:0] op, input logic sel);
    @(negedge clkL); flagOpL = op; flagSelL = sel;
    @(negedge clkL); flagOpL = 0;
  endtask

  task automatic flagR(input logic [1:0] op, input logic sel);
    @(negedge clkR); flagOpR = op; flagSelR = sel;
    @(negedge clkR); flagOpR = 0;
  endtask

  task automatic waitChkL(input bit en, input logic sel, input logic val, input logic exp, input string req);
    @(negedge clkL); testEnL = en; testSelL = sel; testValL = val;
    #1 check(waitL === exp, req, 32'(waitL), 32'(exp));
    testEnL = 0;
  endtask

  task automatic waitChkR(input bit en, input logic sel, input logic val, input logic exp, input string req);
    @(negedge clkR); testEnR = en; testSelR = sel; testValR = val;
    #1 check(waitR === exp, req, 32'(waitR), 32'(exp));
    testEnR = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clkL);
    rstN = 1;
    // R1 reset state
    @(negedge clkL);
    check(memRDataL === 0, "R1 rdL", memRDataL, 0);
    check(memRDataR === 0, "R1 rdR", memRDataR, 0);
    waitChkL(1, 0, 0, 0, "R1 flag0 clear L");
    waitChkL(1, 1, 1, 1, "R1 flag1 clear L");
    waitChkR(1, 0, 1, 1, "R1 flag0 clear R");
    // R2 same-port readback
    accL(1, 5, 32'hA5A5_0001, 0, 0, "");
    accL(0, 5, 0, 1, 32'hA5A5_0001, "R2 left readback");
    // R3 cross-port read
    accR(0, 5, 0, 1, 32'hA5A5_0001, "R3 right reads left word");
    // R4 overlapping writes to different addresses
    fork
      accL(1, 10, 32'h0000_B0B0, 0, 0, "");
      accR(1, 11, 32'h0000_C0C0, 0, 0, "");
    join
    accL(0, 11, 0, 1, 32'h0000_C0C0, "R4 left reads right word");
    accR(0, 10, 0, 1, 32'h0000_B0B0, "R4 right reads left word");
    // R5 latest write wins
    accL(1, 20, 32'hDDDD_0000, 0, 0, "");
    accR(1, 20, 32'hEEEE_0000, 0, 0, "");
    accL(0, 20, 0, 1, 32'hEEEE_0000, "R5 right newer");
    accL(1, 20, 32'hFFFF_0000, 0, 0, "");
    accR(0, 20, 0, 1, 32'hFFFF_0000, "R5 left newer");
    // R6 read during write returns old word
    accL(1, 30, 32'h1111_2222, 0, 0, "");
    accL(1, 30, 32'h3333_4444, 1, 32'h1111_2222, "R6 old word on collision");
    accL(0, 30, 0, 1, 32'h3333_4444, "R6 new word after");
    // R11 right write held over a left write to the same address
    @(negedge clkR); memEnR = 1; memWeR = 1; memAddrR = 40; memWDataR = 32'h7777_0000;
    accL(1, 40, 32'h8888_0000, 0, 0, "");
    @(negedge clkR); memEnR = 0; memWeR = 0;
    accL(0, 40, 0, 1, 32'h7777_0000, "R11 right kept");
    accR(0, 40, 0, 1, 32'h7777_0000, "R11 right kept at R");
    // R7 local set seen next cycle
    flagL(1, 0);
    waitChkL(1, 0, 1, 0, "R7 left sees own set");
    // R8 far side sees it within three of its cycles
    repeat (6) @(negedge clkR);
    waitChkR(1, 0, 1, 0, "R8 right sees left set");
    flagR(2, 0);
    waitChkR(1, 0, 0, 0, "R7 right sees own clear");
    repeat (6) @(negedge clkL);
    waitChkL(1, 0, 1, 1, "R8 left sees right clear");
    // R9 flags independent
    flagL(1, 1);
    waitChkL(1, 1, 1, 0, "R9 flag1 set");
    waitChkL(1, 0, 0, 0, "R9 flag0 unchanged");
    repeat (6) @(negedge clkR);
    waitChkR(1, 1, 1, 0, "R9 right sees flag1");
    waitChkR(1, 0, 1, 1, "R9 right flag0 still clear");
    // R10 no wait when test disabled despite mismatch
    waitChkL(0, 1, 0, 0, "R10 idle test left");
    waitChkR(0, 0, 1, 0, "R10 idle test right");
    waitChkR(1, 1, 0, 1, "R10 mismatch raises wait");
    repeat (4) @(negedge clkL);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule